// File: doc/BRIEF.md
# Instruction Fetch Fault Checker

This block screens every 32-bit instruction fetch address before the address is handed to the instruction cache. For each fetch it produces a corrected address, with the low bits selected by an alignment mask cleared, and up to three fault flags: misaligned fetch, instruction access error and instruction access exception. A protected address region near the top of the map is split into windows. Some windows always fault, and one window faults only while a runtime RAM-enable input is low.

Three checking variants are built in, and an input picks one of them for each fetch. The variants differ in how they treat a misaligned fetch and in where their windows lie. A fourth select value bypasses all checking. The results are registered. They appear on the clock edge after the fetch strobe, together with a one-cycle done pulse.

Top module: `ifetch_fault_chk`

## Requirements
- R1: While reset is asserted and immediately after it is released, `chk_done_o`, all three flags and `chk_addr_o` are 0.
- R2: A fetch presented with `fetch_vld_i` high at one clock edge shows its results at the next edge, with `chk_done_o` high for that one cycle. When `chk_done_o` is low, all three flags are low and `chk_addr_o` holds its last value.
- R3: Variant A (`variant_i` = 0) reports a fetch as an access error when `fetch_addr_i & align_mask_i` is non-zero. It clears the masked bits in the output address and never raises the misaligned flag.
- R4: On variant A, an aligned fetch in 0xFE800000..0xFEFFFFFF is an access error. Variant A never raises an access exception.
- R5: Variant B (`variant_i` = 1) raises the misaligned flag for a fetch with masked bits set and clears those bits. All of its window checks then use the cleared address.
- R6: On variant B, a cleared address in 0xFE800000..0xFEFEFFFF or in 0xFEFF0600..0xFEFF7FFF is an access error.
- R7: On variant B, if no error applies, an address in 0xFE004000..0xFE7FFFFF is an access exception. An address in 0xFE000000..0xFE003FFF is an access exception only while `ram_en_i` is 0.
- R8: Variant C (`variant_i` = 2) clears the masked bits without raising any fault for them. The misaligned flag is never set on variant C.
- R9: On variant C, a cleared address in 0xFE800000..0xFEFFFFFF is an access error. Otherwise an address in 0xFE008000..0xFE7FFFFF is an access exception, and an address in 0xFE000000..0xFE007FFF is an access exception only while `ram_en_i` is 0.
- R10: The error flag and the exception flag are never high together. When an error window and an exception window both match, only the error is reported.
- R11: With `variant_i` = 3 the fetch address passes through unchanged and no flag is raised.
- R12: All window bounds are compared as unsigned values and are inclusive at both ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_vld_i | input | 1 | Fetch strobe, one cycle per address |
| fetch_addr_i | input | 32 | Fetch address |
| align_mask_i | input | 3 | Low address bits that must be zero (3 for word fetches) |
| variant_i | input | 2 | Checking variant: 0 = A, 1 = B, 2 = C, 3 = bypass |
| ram_en_i | input | 1 | RAM-enable; 0 protects the gated window |
| chk_done_o | output | 1 | One-cycle pulse marking valid results |
| chk_addr_o | output | 32 | Corrected fetch address |
| flag_misalign_o | output | 1 | Misaligned fetch fault |
| flag_err_o | output | 1 | Instruction access error |
| flag_exc_o | output | 1 | Instruction access exception |

## Verification
The datapath keeps no state apart from the output register. A wrong window bound or a wrong priority therefore shows as a wrong flag on the done pulse of the very fetch that hit it. The directed vectors sit on and around each window bound, with the RAM-enable input in both states. A broken alignment path shows as non-zero low bits in the corrected address, or as a misaligned flag on the wrong variant, one cycle after the strobe. A stuck register shows when the flags fail to drop on the cycle after a fetch.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

   typedef enum logic [1:0] {
      VAR_A   = 2'd0,
      VAR_B   = 2'd1,
      VAR_C   = 2'd2,
      VAR_BYP = 2'd3
   } ifc_variant_e;

   // window indices
   localparam int W_ERR_WIDE  = 0; // FE800000..FEFFFFFF  (A, C error)
   localparam int W_ERR_SPR   = 1; // FEFF0600..FEFF7FFF  (B error)
   localparam int W_ERR_MID   = 2; // FE800000..FEFEFFFF  (B error)
   localparam int W_EXC_B     = 3; // FE004000..FE7FFFFF  (B exception)
   localparam int W_GATE_B    = 4; // FE000000..FE003FFF  (B gated)
   localparam int W_EXC_C     = 5; // FE008000..FE7FFFFF  (C exception)
   localparam int W_GATE_C    = 6; // FE000000..FE007FFF  (C gated)
   localparam int NUM_WIN     = 7;

   function automatic logic [31:0] win_lo(int idx);
      case (idx)
         W_ERR_WIDE: win_lo = 32'hFE80_0000;
         W_ERR_SPR:  win_lo = 32'hFEFF_0600;
         W_ERR_MID:  win_lo = 32'hFE80_0000;
         W_EXC_B:    win_lo = 32'hFE00_4000;
         W_GATE_B:   win_lo = 32'hFE00_0000;
         W_EXC_C:    win_lo = 32'hFE00_8000;
         default:    win_lo = 32'hFE00_0000;
      endcase
   endfunction

   function automatic logic [31:0] win_hi(int idx);
      case (idx)
         W_ERR_WIDE: win_hi = 32'hFEFF_FFFF;
         W_ERR_SPR:  win_hi = 32'hFEFF_7FFF;
         W_ERR_MID:  win_hi = 32'hFEFE_FFFF;
         W_EXC_B:    win_hi = 32'hFE7F_FFFF;
         W_GATE_B:   win_hi = 32'hFE00_3FFF;
         W_EXC_C:    win_hi = 32'hFE7F_FFFF;
         default:    win_hi = 32'hFE00_7FFF;
      endcase
   endfunction

endpackage

// File: rtl/ifc_align.sv
module ifc_align #(
   parameter int ADDR_W = 32,
   parameter int MASK_W = 3
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [MASK_W-1:0] mask_i,
   output logic [ADDR_W-1:0] aligned_o,
   output logic              mis_o
);
   localparam int PAD_W = ADDR_W - MASK_W;

   logic [ADDR_W-1:0] mask_ext;

   assign mask_ext  = {{PAD_W{1'b0}}, mask_i};
   assign aligned_o = addr_i & ~mask_ext;
   assign mis_o     = |(addr_i[MASK_W-1:0] & mask_i);
endmodule

// File: rtl/ifc_win_cmp.sv
module ifc_win_cmp #(
   parameter int                ADDR_W = 32,
   parameter logic [ADDR_W-1:0] LO     = '0,
   parameter logic [ADDR_W-1:0] HI     = '1
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);
   // unsigned, inclusive at both ends
   assign hit_o = (addr_i >= LO) && (addr_i <= HI);
endmodule

// File: rtl/ifc_classify.sv
module ifc_classify
   import ifc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [1:0]         variant_i,
   input  logic               ram_en_i,
   input  logic               mis_i,
   input  logic [NUM_WIN-1:0] hit_i,
   input  logic [ADDR_W-1:0]  raw_addr_i,
   input  logic [ADDR_W-1:0]  aligned_i,
   output logic [ADDR_W-1:0]  addr_o,
   output logic               mis_f_o,
   output logic               err_f_o,
   output logic               exc_f_o
);
   ifc_variant_e var_e;
   assign var_e = ifc_variant_e'(variant_i);

   always_comb begin
      addr_o  = aligned_i;
      mis_f_o = 1'b0;
      err_f_o = 1'b0;
      exc_f_o = 1'b0;
      unique case (var_e)
         VAR_A: begin
            // misalignment is folded into the error flag
            err_f_o = mis_i | hit_i[W_ERR_WIDE];
         end
         VAR_B: begin
            mis_f_o = mis_i;
            if (hit_i[W_ERR_SPR] || hit_i[W_ERR_MID])
               err_f_o = 1'b1;
            else if (hit_i[W_EXC_B])
               exc_f_o = 1'b1;
            else if (!ram_en_i && hit_i[W_GATE_B])
               exc_f_o = 1'b1;
         end
         VAR_C: begin
            if (hit_i[W_ERR_WIDE])
               err_f_o = 1'b1;
            else if (hit_i[W_EXC_C])
               exc_f_o = 1'b1;
            else if (!ram_en_i && hit_i[W_GATE_C])
               exc_f_o = 1'b1;
         end
         default: begin
            addr_o = raw_addr_i;
         end
      endcase
   end
endmodule

// File: rtl/ifetch_fault_chk.sv
module ifetch_fault_chk
   import ifc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int MASK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_vld_i,
   input  logic [ADDR_W-1:0] fetch_addr_i,
   input  logic [MASK_W-1:0] align_mask_i,
   input  logic [1:0]        variant_i,
   input  logic              ram_en_i,
   output logic              chk_done_o,
   output logic [ADDR_W-1:0] chk_addr_o,
   output logic              flag_misalign_o,
   output logic              flag_err_o,
   output logic              flag_exc_o
);
   initial begin
      assert (ADDR_W == 32) else $error("ifetch_fault_chk: windows need ADDR_W == 32");
      assert (MASK_W >= 1 && MASK_W < ADDR_W) else $error("ifetch_fault_chk: bad MASK_W");
   end

   logic [ADDR_W-1:0]  aligned;
   logic               mis;
   logic [NUM_WIN-1:0] hit;
   logic [ADDR_W-1:0]  c_addr;
   logic               c_mis, c_err, c_exc;

   ifc_align #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_align (
      .addr_i    (fetch_addr_i),
      .mask_i    (align_mask_i),
      .aligned_o (aligned),
      .mis_o     (mis)
   );

   for (genvar wi = 0; wi < NUM_WIN; wi++) begin : g_win
      ifc_win_cmp #(
         .ADDR_W (ADDR_W),
         .LO     (win_lo(wi)),
         .HI     (win_hi(wi))
      ) u_cmp (
         .addr_i (aligned),
         .hit_o  (hit[wi])
      );
   end

   ifc_classify #(.ADDR_W(ADDR_W)) u_cls (
      .variant_i  (variant_i),
      .ram_en_i   (ram_en_i),
      .mis_i      (mis),
      .hit_i      (hit),
      .raw_addr_i (fetch_addr_i),
      .aligned_i  (aligned),
      .addr_o     (c_addr),
      .mis_f_o    (c_mis),
      .err_f_o    (c_err),
      .exc_f_o    (c_exc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_done_o      <= 1'b0;
         chk_addr_o      <= '0;
         flag_misalign_o <= 1'b0;
         flag_err_o      <= 1'b0;
         flag_exc_o      <= 1'b0;
      end else begin
         chk_done_o <= fetch_vld_i;
         if (fetch_vld_i) begin
            chk_addr_o      <= c_addr;
            flag_misalign_o <= c_mis;
            flag_err_o      <= c_err;
            flag_exc_o      <= c_exc;
         end else begin
            flag_misalign_o <= 1'b0;
            flag_err_o      <= 1'b0;
            flag_exc_o      <= 1'b0;
         end
      end
   end

   assert_one_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag_err_o && flag_exc_o));

   assert_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_vld_i |=> chk_done_o);

   assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_done_o |-> !(flag_err_o || flag_exc_o || flag_misalign_o));

   assert_hold_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_vld_i |=> $stable(chk_addr_o));

   assert_a_no_exc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_vld_i && variant_i == VAR_A) |=> !flag_exc_o && !flag_misalign_o);

   assert_c_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_vld_i && variant_i == VAR_C) |=> !flag_misalign_o);

   assert_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_vld_i && variant_i != VAR_BYP) |=>
         ((chk_addr_o[MASK_W-1:0] & $past(align_mask_i)) == '0));

   assert_bypass_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_vld_i && variant_i == VAR_BYP) |=>
         (chk_addr_o == $past(fetch_addr_i)) && !flag_err_o && !flag_exc_o && !flag_misalign_o);
endmodule

// File: tb/ifetch_fault_chk_tb.sv
`timescale 1ns/1ps
module ifetch_fault_chk_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_vld = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic [2:0]  align_mask = 3'd3;
   logic [1:0]  variant = 2'd0;
   logic        ram_en = 1'b1;
   logic        chk_done;
   logic [31:0] chk_addr;
   logic        f_mis, f_err, f_exc;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   ifetch_fault_chk dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .fetch_vld_i     (fetch_vld),
      .fetch_addr_i    (fetch_addr),
      .align_mask_i    (align_mask),
      .variant_i       (variant),
      .ram_en_i        (ram_en),
      .chk_done_o      (chk_done),
      .chk_addr_o      (chk_addr),
      .flag_misalign_o (f_mis),
      .flag_err_o      (f_err),
      .flag_exc_o      (f_exc)
   );

   function automatic bit inw(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
      return (a >= lo) && (a <= hi);
   endfunction

   // expected {addr, misalign, err, exc}
   function automatic logic [34:0] expect_of(logic [31:0] a, logic [2:0] m,
                                              logic [1:0] v, logic r);
      logic [31:0] al;
      logic mi, e, x, mf;
      al = a & ~{29'd0, m};
      mi = |(a[2:0] & m);
      e = 0; x = 0; mf = 0;
      case (v)
         2'd0: e = mi || inw(al, 32'hFE800000, 32'hFEFFFFFF);
         2'd1: begin
            mf = mi;
            if (inw(al, 32'hFEFF0600, 32'hFEFF7FFF) || inw(al, 32'hFE800000, 32'hFEFEFFFF)) e = 1;
            else if (inw(al, 32'hFE004000, 32'hFE7FFFFF)) x = 1;
            else if (!r && inw(al, 32'hFE000000, 32'hFE003FFF)) x = 1;
         end
         2'd2: begin
            if (inw(al, 32'hFE800000, 32'hFEFFFFFF)) e = 1;
            else if (inw(al, 32'hFE008000, 32'hFE7FFFFF)) x = 1;
            else if (!r && inw(al, 32'hFE000000, 32'hFE007FFF)) x = 1;
         end
         default: al = a;
      endcase
      return {al, mf, e, x};
   endfunction

   task automatic check(string req, logic [34:0] got, logic [34:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got addr=%h mis=%b err=%b exc=%b, expected addr=%h mis=%b err=%b exc=%b",
                  req, got[34:3], got[2], got[1], got[0], exp[34:3], exp[2], exp[1], exp[0]);
      end
   endtask

   // drive at negedge, results visible at the following negedge
   task automatic apply(string req, logic [31:0] a, logic [2:0] m, logic [1:0] v, logic r);
      logic [34:0] exp;
      fetch_addr = a; align_mask = m; variant = v; ram_en = r; fetch_vld = 1'b1;
      exp = expect_of(a, m, v, r);
      @(negedge clk);
      fetch_vld = 1'b0;
      check({req, "/done"}, {32'd0, 2'd0, chk_done}, {32'd0, 2'd0, 1'b1});
      check(req, {chk_addr, f_mis, f_err, f_exc}, exp);
      if (f_err && f_exc) begin
         n_chk++; n_fail++;
         $display("FAIL R10: err=%b exc=%b expected not both", f_err, f_exc);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      logic [31:0] held;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      check("R1", {chk_addr, f_mis, f_err, f_exc}, 35'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {chk_addr, f_mis, f_err, chk_done}, 35'd0);

      // variant A
      apply("R3", 32'hFE800002, 3'd3, 2'd0, 1'b1);
      apply("R3", 32'h00001001, 3'd3, 2'd0, 1'b0);
      apply("R4", 32'hFE800000, 3'd3, 2'd0, 1'b1);
      apply("R4", 32'hFE7FFFFC, 3'd3, 2'd0, 1'b0);
      apply("R4", 32'hFEFFFFFC, 3'd3, 2'd0, 1'b1);
      apply("R4", 32'hFE004000, 3'd3, 2'd0, 1'b0);

      // variant B
      apply("R5", 32'hFE000001, 3'd3, 2'd1, 1'b0);
      apply("R5", 32'hFEFF0603, 3'd3, 2'd1, 1'b1);
      apply("R6", 32'hFEFEFFFC, 3'd3, 2'd1, 1'b1);
      apply("R6", 32'hFEFF05FC, 3'd3, 2'd1, 1'b1);
      apply("R6", 32'hFEFF7FFC, 3'd3, 2'd1, 1'b1);
      apply("R6", 32'hFEFF8000, 3'd3, 2'd1, 1'b0);
      apply("R7", 32'hFE004000, 3'd3, 2'd1, 1'b1);
      apply("R7", 32'hFE003FFC, 3'd3, 2'd1, 1'b1);
      apply("R7", 32'hFE003FFC, 3'd3, 2'd1, 1'b0);
      apply("R7", 32'hFE7FFFFC, 3'd3, 2'd1, 1'b1);

      // variant C
      apply("R8", 32'hFE900007, 3'd7, 2'd2, 1'b1);
      apply("R8", 32'h12345673, 3'd3, 2'd2, 1'b1);
      apply("R9", 32'hFE007FFC, 3'd3, 2'd2, 1'b1);
      apply("R9", 32'hFE007FFC, 3'd3, 2'd2, 1'b0);
      apply("R9", 32'hFE008000, 3'd3, 2'd2, 1'b1);
      apply("R9", 32'hFEFFFFFF, 3'd3, 2'd2, 1'b1);

      // priority and bounds
      apply("R10", 32'hFE800000, 3'd3, 2'd1, 1'b0);
      apply("R12", 32'hFDFFFFFC, 3'd3, 2'd2, 1'b0);
      apply("R12", 32'hFF000000, 3'd3, 2'd1, 1'b0);
      apply("R12", 32'h7E000000, 3'd3, 2'd2, 1'b0);

      // bypass
      apply("R11", 32'hFE800003, 3'd3, 2'd3, 1'b0);

      // idle cycles: flags drop, address holds
      held = chk_addr;
      @(negedge clk);
      check("R2", {chk_addr, f_mis, f_err, chk_done}, {held, 3'd0});
      check("R2", {32'd0, 2'd0, f_exc}, 35'd0);

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [31:0] a;
         logic [1:0]  v;
         logic [2:0]  m;
         a = $urandom;
         if (($urandom % 4) != 0) a[31:24] = 8'hFE;
         v = 2'($urandom % 4);
         m = ($urandom % 3 == 0) ? 3'd7 : 3'd3;
         case (v)
            2'd0: apply("R4", a, m, v, 1'($urandom));
            2'd1: apply("R7", a, m, v, 1'($urandom));
            2'd2: apply("R9", a, m, v, 1'($urandom));
            default: apply("R11", a, m, v, 1'($urandom));
         endcase
         if ((i % 7) == 0) @(negedge clk);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule